// File: doc/BRIEF.md
# Flash Synchronous Burst Read Interface

This block is the read side of a flash device's host interface. It offers two read paths. Out of reset the path is asynchronous: with chip enable and output enable low, the data pins follow the word stored at the presented address without any clock. A write to the read configuration register can select the synchronous burst path instead. In that path an address-valid strobe latches a start address. The host clock then counts out a programmable initial latency, and consecutive words stream out, each held for one or two clocks. A WAIT output, whose active level is programmable, tells the host when the data pins do not yet carry valid data.

The storage behind the interface is behavioural. Each word is computed from its own address, so the block needs no memory macro. The burst address simply counts upward through the whole address space. A burst therefore runs across any partition boundary without restarting.

The sequencer has three states. IDLE means no burst is in progress. LATENCY means an address has been latched and the latency is being counted. STREAM means words are being presented.

It has these transitions:
- IDLE to LATENCY on a latch.
- LATENCY to STREAM when the latency count is reached.
- LATENCY or STREAM back to LATENCY on a new latch, which restarts the burst.
- Any state to IDLE when chip enable is high or the mode is asynchronous.

Top module: `flash_burst_rd`

## Requirements
- R1: After reset the configuration register is zero, reads are asynchronous, no burst is active and wait_o sits at its inactive level (high, because the polarity bit is 0).
- R2: In asynchronous mode, with ce_n and oe_n low, dq_oe is 1 and dq_o equals the stored word at addr in the same cycle. The stored word at address a is (a*40503 + 23130) mod 65536.
- R3: The configuration register loads cfg_data on a rising clock edge where cfg_we is 1. Its fields are bit 0 for burst mode (1 = synchronous), bits 3:1 for the latency L, bit 4 for the hold (0 = one clock per word, 1 = two), and bit 5 for the WAIT polarity (1 = active high).
- R4: In burst mode, an edge with ce_n=0 and adv_n=0 latches addr (edge 0) and enters LATENCY. The first word becomes valid after edge L. A latency field of 0 or 1 behaves as 2.
- R5: Word k of a burst is the stored word at start+k, valid from edge L+k*H until the next word, where H is 1 or 2 from the hold bit.
- R6: WAIT is active from the latch edge until the first word is valid and inactive while words are valid. It is also inactive in IDLE and in asynchronous mode. Active means wait_o equals the polarity bit.
- R7: In burst mode, dq_oe is 1 only in STREAM with ce_n and oe_n low. Whenever dq_oe is 0, dq_o is 0.
- R8: The burst address increments modulo 2^ADDR_W with no break at any partition boundary (for example across 0x3FFF to 0x4000, and across 0xFFFF to 0x0000).
- R9: ce_n high turns dq_oe off in the same cycle and ends the burst at the next edge. No data appears again until a new latch completes its latency.
- R10: A latch during LATENCY or STREAM restarts the burst from the new address with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| addr | input | ADDR_W | Word address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_data | input | 6 | Configuration register write value |
| dq_o | output | DATA_W | Read data |
| dq_oe | output | 1 | Data drive enable (0 = pins released) |
| wait_o | output | 1 | WAIT, polarity programmable |

## Verification
Asynchronous reads and the release of the data pins on chip enable are combinational, so the bench samples them a short delay after it changes the inputs, away from any edge. Burst results are counted in edges from the latch edge, which is edge 0. WAIT and a released bus are expected after edges 0 through L-1, and word k after edge L+k*H. The bench samples at each falling edge after those edges, before it drives anything new. A configuration write takes effect at the edge that captures it, so every burst starts at least one edge later.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam int CFG_W = 6;

    typedef struct packed {
        logic       wait_hi;
        logic       hold2;
        logic [2:0] lat;
        logic       sync;
    } rd_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LATENCY = 2'd1,
        ST_STREAM  = 2'd2
    } burst_st_t;

    function automatic logic [2:0] eff_latency(input logic [2:0] field);
        return (field < 3'd2) ? 3'd2 : field;
    endfunction

endpackage

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
    import flash_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output rd_cfg_t          cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= rd_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/flash_data_array.sv
module flash_data_array #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int MUL    = 40503,
    parameter int OFS    = 23130
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PROD_W = ADDR_W + 32;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod    = PROD_W'(rd_addr) * PROD_W'(MUL) + PROD_W'(OFS);
        rd_data = prod[DATA_W-1:0];
    end

endmodule

// File: rtl/flash_burst_fsm.sv
module flash_burst_fsm
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  rd_cfg_t           cfg,
    output burst_st_t         st,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              data_phase,
    output logic              wait_act
);

    burst_st_t  nxt;
    logic [2:0] lat_cnt;
    logic       hold_cnt;
    logic [2:0] lat_lim;
    logic       latch;
    logic       lat_done;

    always_comb begin
        lat_lim  = eff_latency(cfg.lat);
        latch    = !ce_n && cfg.sync && !adv_n;
        lat_done = (lat_cnt == lat_lim);
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (ce_n || !cfg.sync) begin
            nxt = ST_IDLE;
        end else if (latch) begin
            nxt = ST_LATENCY;
        end else begin
            unique case (st)
                ST_IDLE:    nxt = ST_IDLE;
                ST_LATENCY: nxt = lat_done ? ST_STREAM : ST_LATENCY;
                ST_STREAM:  nxt = ST_STREAM;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Burst address and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_addr <= '0;
            lat_cnt    <= '0;
            hold_cnt   <= 1'b0;
        end else if (latch) begin
            burst_addr <= addr;
            lat_cnt    <= 3'd1;
            hold_cnt   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    lat_cnt  <= '0;
                    hold_cnt <= 1'b0;
                end
                ST_LATENCY: begin
                    if (!lat_done) begin
                        lat_cnt <= lat_cnt + 3'd1;
                    end
                end
                ST_STREAM: begin
                    if (cfg.hold2 && !hold_cnt) begin
                        hold_cnt <= 1'b1;
                    end else begin
                        hold_cnt   <= 1'b0;
                        burst_addr <= burst_addr + 1'b1;
                    end
                end
                default: begin
                    lat_cnt  <= '0;
                    hold_cnt <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        data_phase = 1'b0;
        wait_act   = 1'b0;
        unique case (st)
            ST_IDLE:    ;
            ST_LATENCY: wait_act   = 1'b1;
            ST_STREAM:  data_phase = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/flash_burst_rd.sv
module flash_burst_rd
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              wait_o
);

    rd_cfg_t           cfg_q;
    burst_st_t         st;
    logic [ADDR_W-1:0] burst_addr;
    logic              data_phase;
    logic              wait_act;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              cfg_wait_hi;

    flash_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_data),
        .cfg   (cfg_q)
    );

    flash_burst_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .addr       (addr),
        .cfg        (cfg_q),
        .st         (st),
        .burst_addr (burst_addr),
        .data_phase (data_phase),
        .wait_act   (wait_act)
    );

    flash_data_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        cfg_wait_hi = cfg_q.wait_hi;
        rd_addr     = cfg_q.sync ? burst_addr : addr;
        dq_oe       = !ce_n && !oe_n && (cfg_q.sync ? data_phase : 1'b1);
        dq_o        = dq_oe ? rd_data : '0;
        wait_o      = cfg_q.wait_hi ? wait_act : !wait_act;
    end

endmodule

// File: rtl/flash_burst_rd_chk.sv
module flash_burst_rd_chk
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              adv_n,
    input logic              dq_oe,
    input logic              wait_o,
    input logic              wait_hi,
    input burst_st_t         st,
    input logic [ADDR_W-1:0] baddr
);

    assert_ce_ends_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (st == ST_IDLE));

    assert_wait_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATENCY) |-> (!dq_oe && (wait_o == wait_hi)));

    assert_no_skip_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (st != ST_STREAM));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_STREAM) && $past(st == ST_STREAM) && $past(adv_n))
        |-> ((baddr == $past(baddr)) || (baddr == $past(baddr) + 1'b1)));

endmodule

bind flash_burst_rd flash_burst_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .adv_n   (adv_n),
    .dq_oe   (dq_oe),
    .wait_o  (wait_o),
    .wait_hi (cfg_wait_hi),
    .st      (st),
    .baddr   (burst_addr)
);

// File: tb/test_flash_burst_rd.sv
`timescale 1ns/1ps
module test_flash_burst_rd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        adv_n = 1'b1;
    logic [15:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_data = '0;
    logic [15:0] dq_o;
    logic        dq_oe;
    logic        wait_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    flash_burst_rd i_flash_burst_rd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
        .addr(addr), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .dq_o(dq_o), .dq_oe(dq_oe), .wait_o(wait_o)
    );

    function automatic logic [15:0] pat(input logic [15:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503 + 32'd23130;
        return t[15:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        cfg_data = v;
        cfg_we   = 1'b1;
        tick();
        cfg_we   = 1'b0;
    endtask

    // Runs one burst from a falling edge; eff_l is the expected latency.
    task automatic burst(input logic [15:0] a, input int eff_l, input int h,
                         input logic pol, input int words);
        addr  = a;
        ce_n  = 1'b0;
        oe_n  = 1'b0;
        adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        for (int e = 0; e < eff_l + words * h; e++) begin
            if (e > 0) tick();
            if (e < eff_l) begin
                chk("R6 wait active in latency", wait_o, pol);
                chk("R4 no data before latency", dq_oe, 1'b0);
            end else begin
                chk("R4 data valid after latency", dq_oe, 1'b1);
                chk("R5 word value", dq_o, pat(a + 16'((e - eff_l) / h)));
                chk("R6 wait inactive with data", wait_o, !pol);
            end
        end
        ce_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 dq_oe in reset", dq_oe, 1'b0);
        chk("R1 wait inactive in reset", wait_o, 1'b1);
        rst_n = 1'b1;
        tick();

        // R2 asynchronous reads
        ce_n = 1'b0;
        oe_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            addr = 16'(i * 4099 + 7);
            #1;
            chk("R2 async drive", dq_oe, 1'b1);
            chk("R2 async data", dq_o, pat(addr));
            chk("R1 wait inactive async", wait_o, 1'b1);
        end
        oe_n = 1'b1;
        #1;
        chk("R7 released with oe high", dq_o, 16'h0);
        ce_n = 1'b1;
        tick();

        // R3 fields loaded but mode bit 0 keeps async
        wr_cfg(6'b111110);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 16'h1234;
        tick();
        tick();
        chk("R3 async kept", dq_o, pat(16'h1234));
        chk("R3 wait polarity high inactive", wait_o, 1'b0);
        ce_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
        tick();

        // R4 R5 R6 sweep over latency, hold and polarity
        for (int l = 0; l < 8; l++) begin
            for (int h = 0; h < 2; h++) begin
                for (int p = 0; p < 2; p++) begin
                    wr_cfg({1'(p), 1'(h), 3'(l), 1'b1});
                    burst(16'(l * 911 + h * 77 + p * 5), (l < 2) ? 2 : l, h + 1, 1'(p), 4);
                end
            end
        end

        // R8 partition boundary and wrap
        wr_cfg({1'b1, 1'b0, 3'd3, 1'b1});
        burst(16'h3FFD, 3, 1, 1'b1, 6);
        burst(16'hFFFE, 3, 1, 1'b1, 4);

        // R7 oe high during stream
        addr = 16'h0100; ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        tick(); tick(); tick();
        chk("R7 stream driven", dq_o, pat(16'h0100));
        oe_n = 1'b1;
        #1;
        chk("R7 oe high releases", dq_oe, 1'b0);
        chk("R7 released data zero", dq_o, 16'h0);
        oe_n = 1'b0;

        // R10 restart mid-stream
        addr = 16'h5555; adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        chk("R10 wait after restart", wait_o, 1'b1);
        chk("R10 no data after restart", dq_oe, 1'b0);
        tick(); tick();
        chk("R10 restart no early data", dq_oe, 1'b0);
        tick();
        chk("R10 restart first word", dq_o, pat(16'h5555));
        tick();
        chk("R10 restart second word", dq_o, pat(16'h5556));

        // R9 chip enable termination
        ce_n = 1'b1;
        #1;
        chk("R9 immediate release", dq_oe, 1'b0);
        tick();
        ce_n = 1'b0;
        #1;
        chk("R9 no resume", dq_oe, 1'b0);
        chk("R9 wait inactive idle", wait_o, 1'b0);
        tick(); tick(); tick(); tick();
        chk("R9 still idle", dq_oe, 1'b0);
        ce_n = 1'b1;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule